// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver Controller

This block moves bytes across a three-wire synchronous serial link: a shift clock, a data output and a data input. A host writes bytes into a one-entry transmit buffer. When the shift register is idle, the buffer is copied into it and the bits go out least significant bit first. Data changes on the falling edge of the shift clock and is captured on the rising edge. At the same time, the incoming bits are assembled into a receive byte that the host collects.

The shift clock has two sources. In the internal mode the block divides the system clock and drives the clock pin. In the external mode it receives the clock through a synchronizer. A small control word carries four groups of settings: the mode fields, the transmit and receive enables, a ready-handshake output enable, and a transmit interrupt with a selectable source.

Clearing both enables resets the whole datapath. Setting transmit enable forces both transmit flags high and raises an interrupt request. After a buffer write, the shift-complete flag drops only after a deliberate delay of roughly one shift clock.

Transmit data enters through a valid/ready port. `tx_ready` is the buffer-empty condition while transmit is enabled, and a byte is taken on any cycle where both `tx_valid` and `tx_ready` are high. While the buffer holds an untransferred byte, `tx_ready` stays low and the host must keep its byte waiting. Receive data leaves through a valid/ready port. `rx_valid` holds until a cycle with `rx_ready` high. A byte that completes while the previous one is still unread is dropped.

Top module: `csio_ctrl`

## Requirements
- R1: Reset, or holding transmit enable and receive enable both at 0, clears the datapath to its idle state: `shift_done`=1, `tx_empty`=1, `rx_valid`=0, `sclk_out`=1, `sdo`=1.
- R2: The control word `ctl_wdata` has this layout:
  - bit0 = external clock select
  - bit1 = interrupt source
  - bit2 = ready-output enable
  - bit3 = transmit enable
  - bit4 = receive enable
  - bit5 = interrupt enable

  Bits 0 to 2 take effect only when written while both enables are 0. Otherwise they are ignored. Bits 3 to 5 take effect on every write.
- R3: A write that changes transmit enable from 0 to 1 forces `tx_empty`=1 and `shift_done`=1 and sets `irq_pend`, whatever interrupt source is selected.
- R4: `irq_pend` stays set until a cycle with `irq_clr`=1. `irq` is 1 only while `irq_pend`=1 and interrupt enable=1. The request is recorded even when interrupt enable is 0.
- R5: A transmit byte is accepted only when `tx_valid`=1 and `tx_ready`=1. `tx_ready`=1 requires transmit enable and an empty buffer. After an accept, `tx_ready` stays 0 until the byte has moved into the shift register.
- R6: After an accepted write, `shift_done` falls no sooner than 0.5 and no later than 1.5 shift-clock periods, plus at most two system clocks of register latency.
- R7: Internal mode (bit0=0) has these properties:
  - `sclk_oe`=1, and `sclk_out` idles high.
  - Each transfer produces exactly 8 low pulses of period 2*HALF_DIV system clocks.
  - `sdo` presents the byte LSB first and changes after falling edges.
- R8: When receive is enabled, the bit on `sdi` at each rising edge is shifted in LSB first. After the 8th bit, `rx_valid`=1 and `rx_data` holds the byte. An accept with `rx_ready` empties it. A byte that completes while `rx_valid`=1 and no accept occurs is discarded and `rx_data` is kept.
- R9: `rdy_out`=1 exactly when receive enable=1, ready-output enable=1 and `rx_valid`=0.
- R10: With interrupt source 0, `irq_pend` sets when the buffer moves into the shift register. With interrupt source 1, it sets when the 8th bit completes.
- R11: External mode (bit0=1) works as follows:
  - `sclk_oe`=0, and `sclk_in` passes through a synchronizer.
  - A buffered byte loads on the first synchronized rising edge after the write.
  - A load happens only while transmit enable, receive enable and ready-output enable are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word (layout in R2) |
| irq_clr | input | 1 | Clears the latched interrupt request |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit buffer can take a byte |
| tx_data | input | DATA_W | Transmit byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Host takes the received byte |
| rx_data | output | DATA_W | Received byte |
| tx_empty | output | 1 | Transmit buffer empty flag |
| shift_done | output | 1 | Transmit shift complete flag |
| irq_pend | output | 1 | Latched transmit interrupt request |
| irq | output | 1 | Gated transmit interrupt |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Internal shift clock |
| sclk_oe | output | 1 | Shift clock pin drive enable |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| rdy_out | output | 1 | Ready handshake to the peer |

## Verification
The bench builds the block with `HALF_DIV`=3, `DATA_W`=8 and a two-stage synchronizer, so one internal shift clock lasts six system clocks. With this setting the 0.5 to 1.5 clock window for the fall of `shift_done` is a span of only a few cycles, and bounding that delay catches an off-by-one tick in the arm-and-load sequence. The short period also lets a single run cover internal loopback, back-to-back bytes with a receive overrun, both interrupt sources, a datapath reset mid-transfer, and external-clock transfers driven from the bench. In those external-clock transfers, the bench holds each clock phase for six cycles, which is well above the synchronizer latency.

// File: rtl/csio_pkg.sv
package csio_pkg;
  typedef struct packed {
    logic irq_en;
    logic rx_en;
    logic tx_en;
    logic rdy_en;
    logic irq_src;
    logic ext_clk;
  } csio_ctl_t;

  localparam int CTL_W = $bits(csio_ctl_t);
endpackage

// File: rtl/csio_clkgen.sv
module csio_clkgen #(
  parameter int HALF_DIV = 4,
  parameter int SYNC_N   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_mode,
  input  logic run,
  input  logic sclk_pin,
  output logic rise_ev,
  output logic fall_ev,
  output logic sclk_int
);
  localparam int DW = $clog2(HALF_DIV + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q;
  logic          tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end
  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sclk_int <= 1'b1;
    else if (!run)    sclk_int <= 1'b1;
    else if (tick)    sclk_int <= ~sclk_int;
  end

  // external clock synchronizer chain, idle level high
  logic [SYNC_N-1:0] sync_q;
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_N; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[gi] <= 1'b1;
        else        sync_q[gi] <= (gi == 0) ? sclk_pin : sync_q[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  logic ext_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev <= 1'b1;
    else        ext_prev <= sync_q[SYNC_N-1];
  end

  logic ext_rise, ext_fall, int_rise, int_fall;
  assign ext_rise = !ext_prev &&  sync_q[SYNC_N-1];
  assign ext_fall =  ext_prev && !sync_q[SYNC_N-1];
  // while idle every tick counts as a rising edge of a clock held high
  assign int_fall = tick && run && sclk_int;
  assign int_rise = tick && (!run || !sclk_int);

  assign rise_ev = ext_mode ? ext_rise : int_rise;
  assign fall_ev = ext_mode ? ext_fall : int_fall;
endmodule

// File: rtl/csio_shifter.sv
module csio_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sdi,
  output logic              busy,
  output logic              sdo,
  output logic              done_pulse,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sr, rx_sr;
  logic [BW-1:0]     bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0; rx_sr <= '0; bit_q <= '0;
      busy <= 1'b0; sdo <= 1'b1; done_pulse <= 1'b0; rx_byte <= '0;
    end else if (clr) begin
      busy <= 1'b0; sdo <= 1'b1; done_pulse <= 1'b0; bit_q <= '0;
    end else begin
      done_pulse <= 1'b0;
      if (load) begin
        tx_sr <= load_data;
        busy  <= 1'b1;
        bit_q <= '0;
      end else if (busy && fall_ev) begin
        sdo   <= tx_sr[0];
        tx_sr <= tx_sr >> 1;
      end else if (busy && rise_ev) begin
        rx_sr <= {sdi, rx_sr[DATA_W-1:1]};
        bit_q <= bit_q + 1'b1;
        if (bit_q == BIT_LAST) begin
          busy       <= 1'b0;
          done_pulse <= 1'b1;
          rx_byte    <= {sdi, rx_sr[DATA_W-1:1]};
        end
      end
    end
  end
endmodule

// File: rtl/csio_ctrl.sv
module csio_ctrl
  import csio_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              irq_clr,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_empty,
  output logic              shift_done,
  output logic              irq_pend,
  output logic              irq,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              sdo,
  input  logic              sdi,
  output logic              rdy_out
);
  csio_ctl_t ctl_q, ctl_w;
  assign ctl_w = csio_ctl_t'(ctl_wdata);

  logic tx_on, rx_on, ie_on;
  assign tx_on = ctl_q.tx_en;
  assign rx_on = ctl_q.rx_en;
  assign ie_on = ctl_q.irq_en;

  logic both_off, tx_en_rise;
  assign both_off   = !tx_on && !rx_on;
  assign tx_en_rise = ctl_wr && ctl_w.tx_en && !tx_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (ctl_wr) begin
      ctl_q.tx_en  <= ctl_w.tx_en;
      ctl_q.rx_en  <= ctl_w.rx_en;
      ctl_q.irq_en <= ctl_w.irq_en;
      if (both_off) begin
        ctl_q.ext_clk <= ctl_w.ext_clk;
        ctl_q.irq_src <= ctl_w.irq_src;
        ctl_q.rdy_en  <= ctl_w.rdy_en;
      end
    end
  end

  logic rise_ev, fall_ev, sclk_int, busy, done_pulse, load, armed, pend;
  logic [DATA_W-1:0] tx_buf, rx_byte;

  csio_clkgen #(.HALF_DIV(HALF_DIV), .SYNC_N(SYNC_N)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .ext_mode(ctl_q.ext_clk), .run(busy),
    .sclk_pin(sclk_in), .rise_ev(rise_ev), .fall_ev(fall_ev), .sclk_int(sclk_int)
  );

  csio_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .clr(both_off), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .load(load), .load_data(tx_buf), .sdi(sdi), .busy(busy), .sdo(sdo),
    .done_pulse(done_pulse), .rx_byte(rx_byte)
  );

  // a full buffer waits for an idle shifter; external mode also needs the handshake enables
  assign pend = !tx_empty && !busy && tx_on &&
                (!ctl_q.ext_clk || (rx_on && ctl_q.rdy_en));
  // internal mode loads on the second edge after arming, giving 0.5..1.5 clock delay
  assign load = rise_ev && pend && (ctl_q.ext_clk || armed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             armed <= 1'b0;
    else if (!pend || load) armed <= 1'b0;
    else if (rise_ev)       armed <= 1'b1;
  end

  logic tx_acc, rx_acc;
  assign tx_ready = tx_on && tx_empty;
  assign tx_acc   = tx_valid && tx_ready;
  assign rx_acc   = rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty <= 1'b1; shift_done <= 1'b1; tx_buf <= '0;
    end else if (both_off || tx_en_rise) begin
      tx_empty <= 1'b1; shift_done <= 1'b1;
    end else begin
      if (tx_acc) begin
        tx_empty <= 1'b0;
        tx_buf   <= tx_data;
      end else if (load) tx_empty <= 1'b1;
      if (load)            shift_done <= 1'b0;
      else if (done_pulse) shift_done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0; rx_data <= '0;
    end else if (both_off) begin
      rx_valid <= 1'b0;
    end else if (done_pulse && rx_on && (!rx_valid || rx_acc)) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_byte;
    end else if (rx_acc) begin
      rx_valid <= 1'b0;
    end
  end

  logic src_ev;
  assign src_ev = ctl_q.irq_src ? done_pulse : load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              irq_pend <= 1'b0;
    else if (tx_en_rise || (src_ev && tx_on)) irq_pend <= 1'b1;
    else if (irq_clr)                        irq_pend <= 1'b0;
  end

  assign irq      = irq_pend && ie_on;
  assign rdy_out  = rx_on && ctl_q.rdy_en && !rx_valid;
  assign sclk_out = sclk_int;
  assign sclk_oe  = !ctl_q.ext_clk;
endmodule

// File: rtl/csio_ctrl_chk.sv
module csio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_on,
  input logic       rx_on,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_empty,
  input logic       shift_done,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_lo,
  input logic       irq_pend,
  input logic       irq_clr
);
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_on && !rx_on) |=> (shift_done && tx_empty && !rx_valid)); // R1

  AST_TXEN_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_on) |-> (tx_empty && shift_done && irq_pend)); // R3

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_pend) |-> $past(irq_clr)); // R4

  AST_TX_BACKPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready); // R5

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && rx_on) |=> (rx_valid && $stable(rx_lo))); // R8
endmodule

bind csio_ctrl csio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_on(tx_on), .rx_on(rx_on),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_empty(tx_empty),
  .shift_done(shift_done), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_lo(rx_data[7:0]), .irq_pend(irq_pend), .irq_clr(irq_clr)
);

// File: tb/csio_ctrl_bench.sv
module csio_ctrl_bench;
  localparam int W  = 8;
  localparam int HD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 1'b0, irq_clr = 1'b0, tx_valid = 1'b0, rx_ready = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic [W-1:0] tx_data = '0, rx_data;
  logic tx_ready, rx_valid, tx_empty, shift_done, irq_pend, irq;
  logic sclk_in = 1'b1, sclk_out, sclk_oe, sdo, sdi, rdy_out;
  logic loop_on = 1'b1, use_ext = 1'b0, mon_on = 1'b0;
  logic [W-1:0] cap = '0;
  int npulse = 0, total = 0, bad = 0;

  always #5 clk = ~clk;
  assign sdi = loop_on ? sdo : 1'b0;

  csio_ctrl #(.DATA_W(W), .HALF_DIV(HD), .SYNC_N(2)) u_csio_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .irq_clr(irq_clr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_empty(tx_empty), .shift_done(shift_done), .irq_pend(irq_pend), .irq(irq),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdo(sdo), .sdi(sdi),
    .rdy_out(rdy_out)
  );

  logic sclk_mon;
  assign sclk_mon = use_ext ? sclk_in : sclk_out;
  always @(posedge sclk_mon) if (mon_on) begin
    cap    <= {sdo, cap[W-1:1]};
    npulse <= npulse + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [5:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic send(input logic [W-1:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  // returns cycles waited, -1 on timeout
  task automatic wait_sd(input logic v, input int maxc, output int n);
    n = 0;
    while (shift_done != v && n < maxc) begin @(negedge clk); n++; end
    if (shift_done != v) n = -1;
  endtask

  task automatic ext_pulse();
    @(negedge clk); sclk_in = 1'b0;
    repeat (6) @(negedge clk);
    sclk_in = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 shift_done", shift_done, 1);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 sclk_out", sclk_out, 1);
    chk("R1 sdo", sdo, 1);
    chk("R5 tx_ready off", tx_ready, 0);
    chk("R4 irq idle", irq, 0);
  endtask

  task automatic t_cfg_lock();
    wr_ctl(6'h14);            // rx + rdy while both off
    chk("R9 rdy_out on", rdy_out, 1);
    wr_ctl(6'h15);            // ext select while rx on: ignored
    chk("R2 ext ignored", sclk_oe, 1);
  endtask

  task automatic t_tx_enable();
    wr_ctl(6'h1C);            // tx + rx + rdy, irq disabled
    chk("R3 tx_empty", tx_empty, 1);
    chk("R3 shift_done", shift_done, 1);
    chk("R3 irq_pend", irq_pend, 1);
    chk("R4 irq gated", irq, 0);
    repeat (3) @(negedge clk);
    chk("R4 pend held", irq_pend, 1);
    pulse_clr();
    chk("R4 pend cleared", irq_pend, 0);
    wr_ctl(6'h3C);            // irq enable
    chk("R4 irq after clr", irq, 0);
  endtask

  task automatic t_int_xfer();
    int n;
    mon_on = 1'b1; npulse = 0;
    send(8'hA5);
    chk("R5 tx_ready low after accept", tx_ready, 0);
    wait_sd(1'b0, 40, n);
    chk("R6 delay min", (n + 1 >= HD) ? 1 : 0, 1);
    chk("R6 delay max", (n >= 0 && n + 1 <= 3*HD + 2) ? 1 : 0, 1);
    chk("R10 irq at load", irq_pend, 1);
    chk("R4 irq out", irq, 1);
    chk("R5 tx_ready after load", tx_ready, 1);
    wait_sd(1'b1, 200, n);
    mon_on = 1'b0;
    chk("R7 pulse count", npulse, 8);
    chk("R7 lsb first", cap, 8'hA5);
    chk("R7 idle high", sclk_out, 1);
    chk("R8 rx_valid", rx_valid, 1);
    chk("R8 rx_data", rx_data, 8'hA5);
    chk("R9 rdy_out while full", rdy_out, 0);
    pulse_clr();
    pop();
    chk("R8 popped", rx_valid, 0);
    chk("R9 rdy_out free", rdy_out, 1);
  endtask

  task automatic t_overrun();
    int n;
    send(8'h3C);
    send(8'h81);
    repeat (4) @(negedge clk);
    wait_sd(1'b1, 200, n);
    chk("R8 first byte", rx_data, 8'h3C);
    wait_sd(1'b0, 40, n);
    wait_sd(1'b1, 200, n);
    chk("R8 overrun keeps", rx_data, 8'h3C);
    chk("R8 still valid", rx_valid, 1);
    pop();
  endtask

  task automatic t_clear_and_src();
    int n;
    send(8'hFF);
    repeat (15) @(negedge clk);
    wr_ctl(6'h00);
    repeat (3) @(negedge clk);
    chk("R1 clr shift_done", shift_done, 1);
    chk("R1 clr tx_empty", tx_empty, 1);
    chk("R1 clr sclk", sclk_out, 1);
    chk("R1 clr sdo", sdo, 1);
    wr_ctl(6'h02);            // source = shift complete
    wr_ctl(6'h3A);            // ie + rx + tx, rdy off
    chk("R9 rdy disabled", rdy_out, 0);
    pulse_clr();
    send(8'h0F);
    wait_sd(1'b0, 40, n);
    chk("R10 no irq at load", irq_pend, 0);
    wait_sd(1'b1, 200, n);
    @(negedge clk);
    chk("R10 irq at done", irq_pend, 1);
    chk("R8 rx 0F", rx_data, 8'h0F);
    pop();
    pulse_clr();
  endtask

  task automatic t_ext();
    int n;
    wr_ctl(6'h00);
    wr_ctl(6'h19);            // ext + tx + rx, ready output off
    chk("R11 sclk_oe", sclk_oe, 0);
    send(8'h66);
    repeat (3) ext_pulse();
    chk("R11 gated no load", tx_empty, 0);
    chk("R11 gated shift_done", shift_done, 1);
    wr_ctl(6'h00);
    wr_ctl(6'h1D);            // ext + rdy + tx + rx
    send(8'h5A);
    repeat (8) @(negedge clk);
    chk("R11 waits for edge", shift_done, 1);
    use_ext = 1'b1;
    ext_pulse();
    chk("R11 loaded on rise", shift_done, 0);
    npulse = 0; mon_on = 1'b1;
    repeat (8) ext_pulse();
    mon_on = 1'b0;
    wait_sd(1'b1, 10, n);
    chk("R11 done", shift_done, 1);
    chk("R11 sdo lsb first", cap, 8'h5A);
    chk("R8 ext rx", rx_data, 8'h5A);
    use_ext = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg_lock();
    t_tx_enable();
    t_int_xfer();
    t_overrun();
    t_clear_and_src();
    t_ext();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule